// File: doc/BRIEF.md
# Multi-Mode Planar Pixel Serializer

This block turns one 32-bit display-memory word, holding four 8-bit planes, into a stream of eight 4-bit pixel values, one for each dot-clock enable. Plane n sits in bits 8n+7 down to 8n of the word. Three ways of gathering bits are offered. The planar 16-colour mode takes one bit from each plane per pixel. The packed interleaved mode takes bit pairs from a pair of planes. The 256-colour nibble mode emits whole nibbles, and its nibble order within a plane can be reversed.

A load strobe captures a word together with the mode and direction controls. The mode used for a word is therefore fixed for all eight of its pixels. Each dot-clock enable then advances to the next pixel. When the eighth pixel has been consumed and no new word has been loaded, the valid flag falls.

Top module: `pixel_serializer`

## Requirements
- R1: Mode is decoded at load: `sel_256`=1 selects nibble mode regardless of `sel_ileave`; both 0 selects planar mode; `sel_256`=0 with `sel_ileave`=1 selects packed mode.
- R2: Planar mode: pixel i (i=0..7) has bit n equal to bit 7-i of plane n, where plane n is `word_in[8n+7:8n]`.
- R3: Packed mode: pixels 0-3 use planes 2 (high) and 0 (low), pixels 4-7 use planes 3 and 1; pixel i is {hi[7-2k:6-2k], lo[7-2k:6-2k]} with k = i mod 4.
- R4: Nibble mode with `nib_right`=0 emits plane0[7:4], plane0[3:0], plane1[7:4], ... ending with plane3[3:0].
- R5: Nibble mode with `nib_right`=1 emits plane0[3:0], plane0[7:4], plane1[3:0], ... ending with plane3[7:4].
- R6: After a clock edge with `load`=1, `pix_valid`=1 and `pix` shows pixel 0 of the new word; load takes precedence over `dot_en` in the same cycle.
- R7: Each `dot_en` while valid advances one pixel; the eighth `dot_en` without a new load clears `pix_valid`; `pix` reads 0 whenever `pix_valid`=0; reset leaves `pix_valid`=0.
- R8: With `load` and `dot_en` both low, `pix` and `pix_valid` hold.
- R9: Changes of `sel_256`, `sel_ileave` and `nib_right` between loads have no effect on the pixels of the current word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Capture `word_in` and mode controls |
| dot_en | input | 1 | Advance to next pixel |
| word_in | input | 32 | Four planes, plane n at bits 8n+7:8n |
| sel_256 | input | 1 | Nibble (256-colour) mode select, dominant |
| sel_ileave | input | 1 | Packed interleave select |
| nib_right | input | 1 | Nibble order: 0 high-first, 1 low-first |
| pix | output | 4 | Current pixel value |
| pix_valid | output | 1 | Pixel value is valid |

## Verification
Every combination of the three control bits is tried with walking-one words, a word with distinct nibbles in every plane, and pseudo-random words. A walking one shows exactly which plane bit feeds which pixel bit and which step, which separates the three gathering patterns and the two nibble orders. Distinct nibbles make a swapped plane pair or a swapped nibble show up at once. Further sequences place idle cycles inside a word, flip the control bits in the middle of a word, and assert load together with dot_en, to exercise holding, load-time sampling and load precedence.

// File: rtl/pixel_serializer.sv
module pixel_serializer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic        dot_en,
  input  logic [31:0] word_in,
  input  logic        sel_256,
  input  logic        sel_ileave,
  input  logic        nib_right,
  output logic [3:0]  pix,
  output logic        pix_valid
);
  localparam int PLANES = 4;
  localparam int PW     = 8;
  localparam int NPIX   = 8;
  localparam int IW     = $clog2(NPIX);

  typedef enum logic [1:0] {M_PLANAR, M_PACKED, M_NIBBLE} mode_t;

  logic [31:0]   word_q;
  mode_t         mode_q;
  logic          right_q;
  logic [IW-1:0] idx;
  logic          valid_q;
  logic [PW-1:0] pl [PLANES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q  <= '0;
      mode_q  <= M_PLANAR;
      right_q <= 1'b0;
      idx     <= '0;
      valid_q <= 1'b0;
    end else if (load) begin
      word_q  <= word_in;
      mode_q  <= sel_256 ? M_NIBBLE : (sel_ileave ? M_PACKED : M_PLANAR);
      right_q <= nib_right;
      idx     <= '0;
      valid_q <= 1'b1;
    end else if (dot_en && valid_q) begin
      idx <= idx + 1'b1;
      if (idx == IW'(NPIX-1)) valid_q <= 1'b0;
    end
  end

  logic [3:0] planar_pix, packed_pix, nibble_pix;
  logic [PW-1:0] hi_sh, lo_sh, np;

  for (genvar g = 0; g < PLANES; g++) begin : g_plane
    assign pl[g]         = word_q[g*PW +: PW];
    assign planar_pix[g] = pl[g][3'd7 - idx];
  end

  assign hi_sh      = pl[{1'b1, idx[2]}] << {idx[1:0], 1'b0};
  assign lo_sh      = pl[{1'b0, idx[2]}] << {idx[1:0], 1'b0};
  assign packed_pix = {hi_sh[7:6], lo_sh[7:6]};

  assign np         = pl[idx[2:1]];
  assign nibble_pix = (idx[0] == right_q) ? np[7:4] : np[3:0];

  always_comb begin
    pix = 4'h0;
    if (valid_q) begin
      case (mode_q)
        M_PACKED: pix = packed_pix;
        M_NIBBLE: pix = nibble_pix;
        default:  pix = planar_pix;
      endcase
    end
  end

  assign pix_valid = valid_q;

  // R6
  load_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> pix_valid);

  // R7
  last_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && dot_en && !load && idx == IW'(NPIX-1)) |=> !pix_valid);

  // R7
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |-> pix == 4'h0);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !dot_en) |=> ($stable(pix) && $stable(pix_valid)));

  // R9
  mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(mode_q) && $stable(right_q)));
endmodule

// File: tb/pixel_serializer_bench.sv
module pixel_serializer_bench;
  localparam int CLK_NS = 10;

  logic clk = 0, rst_n = 0, load = 0, dot_en = 0;
  logic [31:0] word_in = '0;
  logic sel_256 = 0, sel_ileave = 0, nib_right = 0;
  logic [3:0] pix;
  logic pix_valid;
  int checks = 0, errors = 0;
  logic [31:0] lcg = 32'h1234_5678;

  always #(CLK_NS/2) clk = ~clk;

  pixel_serializer u_pixel_serializer (.*);

  function automatic logic [3:0] ref_pix(logic [31:0] w, logic s256, logic sil,
                                          logic rgt, int i);
    logic [3:0] p;
    logic [7:0] hi, lo, pn;
    int k;
    if (s256) begin
      pn = w[8*(i/2) +: 8];
      if (((i % 2) == 0) != rgt) p = pn[7:4]; else p = pn[3:0];
    end else if (sil) begin
      k  = i % 4;
      hi = w[8*(2 + i/4) +: 8];
      lo = w[8*(i/4) +: 8];
      p  = {hi[7-2*k], hi[6-2*k], lo[7-2*k], lo[6-2*k]};
    end else begin
      for (int b = 0; b < 4; b++) p[b] = w[8*b + 7 - i];
    end
    return p;
  endfunction

  task automatic chk(string req, logic [3:0] ep, logic ev);
    checks++;
    if (pix !== ep || pix_valid !== ev) begin
      errors++;
      $display("FAIL %s pix=%h valid=%b expected pix=%h valid=%b", req, pix, pix_valid, ep, ev);
    end
  endtask

  task automatic step(logic ld, logic de);
    @(negedge clk); load = ld; dot_en = de;
    @(posedge clk); #1;
    @(negedge clk); load = 0; dot_en = 0;
  endtask

  task automatic run_word(logic [31:0] w, logic s256, logic sil, logic rgt, string req);
    @(negedge clk); word_in = w; sel_256 = s256; sel_ileave = sil; nib_right = rgt;
    step(1, 0);
    for (int i = 0; i < 8; i++) begin
      chk(req, ref_pix(w, s256, sil, rgt, i), 1'b1);
      step(0, 1);
    end
    chk("R7", 4'h0, 1'b0);
  endtask

  function automatic string req_of(logic s256, logic sil, logic rgt);
    if (s256) return rgt ? "R5/R1" : "R4/R1";
    return sil ? "R3/R1" : "R2/R1";
  endfunction

  initial begin
    #(CLK_NS * 20000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1; chk("R7 reset", 4'h0, 1'b0);
    @(negedge clk); rst_n = 1;

    for (int m = 0; m < 8; m++) begin
      for (int b = 0; b < 32; b++)
        run_word(32'h1 << b, m[2], m[1], m[0], req_of(m[2], m[1], m[0]));
      run_word(32'h6745_2301, m[2], m[1], m[0], req_of(m[2], m[1], m[0]));
      run_word(32'hFEDC_BA98, m[2], m[1], m[0], req_of(m[2], m[1], m[0]));
      for (int r = 0; r < 20; r++) begin
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        run_word(lcg, m[2], m[1], m[0], req_of(m[2], m[1], m[0]));
      end
    end

    // R4 explicit example: left order yields 0..7
    @(negedge clk); word_in = 32'h6745_2301; sel_256 = 1; nib_right = 0;
    step(1, 0);
    for (int i = 0; i < 8; i++) begin chk("R4 example", 4'(i), 1'b1); step(0, 1); end
    // R5 explicit example: right order yields 1,0,3,2,...
    @(negedge clk); nib_right = 1;
    step(1, 0);
    for (int i = 0; i < 8; i++) begin chk("R5 example", 4'(i ^ 1), 1'b1); step(0, 1); end

    // R8 hold and R9 mid-word control change
    @(negedge clk); word_in = 32'hA5C3_1E78; sel_256 = 0; sel_ileave = 1; nib_right = 0;
    step(1, 0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); sel_256 = i[0]; sel_ileave = i[1]; nib_right = ~nib_right;
      word_in = ~word_in;
      step(0, 0);
      chk("R8 hold", ref_pix(32'hA5C3_1E78, 0, 1, 0, i), 1'b1);
      chk("R9 controls ignored", ref_pix(32'hA5C3_1E78, 0, 1, 0, i), 1'b1);
      step(0, 1);
    end
    chk("R7 drop", 4'h0, 1'b0);
    step(0, 1);
    chk("R7 dot_en while idle", 4'h0, 1'b0);

    // R6 reload mid-word with dot_en high: load wins
    @(negedge clk); word_in = 32'h0F0F_F0F0; sel_256 = 0; sel_ileave = 0;
    step(1, 0); step(0, 1); step(0, 1);
    @(negedge clk); word_in = 32'h1357_9BDF; sel_256 = 1; nib_right = 0;
    step(1, 1);
    chk("R6 load over dot_en", ref_pix(32'h1357_9BDF, 1, 0, 0, 0), 1'b1);
    step(0, 1);
    chk("R6 next pixel", ref_pix(32'h1357_9BDF, 1, 0, 0, 1), 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule